// File: doc/BRIEF.md
# Dual-Rank Configuration Register Bank

This block holds the 16-bit configuration words that a host loads over a parallel microprocessor port with a 7-bit address. The words are meant for a multi-channel datapath. Every configuration word has two ranks. The master rank is clocked by the rising (trailing) edge of the active-low host write strobe and cannot be read back. The slave rank runs on the device clock; it feeds the datapath and supplies every host read of a configuration address. Each channel has its own master set and its own slave set. A write goes to one selected channel, or to all channels when broadcast is on.

Master contents move into the slave rank in one of two ways. In immediate mode the move happens by itself a fixed number of device clocks after the write strobe has been synchronised into the device clock domain. In event mode the move waits for a one-cycle sync pulse, and a hold bit can block it. The transfer covers every channel that has been written since its last transfer, and it copies that channel's whole master set. The hard reset clears both ranks and the two control words. The soft reset clears only the device-clock state.

Top module: `cfg_dual_rank_bank`

## Requirements
- R1: While `hard_rst_n` is low, the master rank, the slave rank, the main control word and the device control word are all cleared. After a hard reset every read returns 0x0000, and a later transfer of a channel carries 0x0000 for each register not written since that reset.
- R2: While `soft_rst_n` is low (and hard reset is high), the slave rank and the pending-transfer state are cleared, and the master rank and both control words keep their values. A later transfer therefore shows the master values from before the soft reset.
- R3: `host_doe` is 1 exactly while `rd_n` is low, and `host_dout` is 0x0000 otherwise. A read of address 0x0C returns the main control word, and a read of address 0x78 returns the device control word. A read of configuration address 0x00..NREG-1 returns the slave value of that register for the channel selected by device control bits [2:1]. Any other address reads as 0x0000.
- R4: A write to a configuration address changes only the master rank. The slave value read back straight after the strobe is still the previous one.
- R5: When main control bit 15 is 1 (immediate mode), the transfer takes effect on the 7th rising device clock edge after the write strobe returns high. It is not visible after 5 edges, and it is visible after 7.
- R6: When main control bit 15 is 0 (event mode), no transfer happens without `evt_sync`. A one-cycle `evt_sync` pulse sampled high while hold is clear transfers all written channels on that same clock edge.
- R7: Main control bit 12 (hold) blocks event-mode transfers and keeps the written state pending. Once hold is cleared, the next `evt_sync` pulse transfers it. Hold has no effect in immediate mode.
- R8: When device control bit 0 (broadcast) is 1, a configuration write loads that register in every channel's master set. When bit 0 is 0, the write loads only the channel given by device control bits [2:1].
- R9: A transfer copies the complete master set of each channel written since that channel's last transfer. It leaves the slave sets of the channels that were not written unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| hard_rst_n | input | 1 | Active-low hard reset; clears both ranks and the control words |
| soft_rst_n | input | 1 | Active-low soft reset; clears the device-clock state only |
| wr_n | input | 1 | Active-low host write strobe; the rising edge captures the data |
| rd_n | input | 1 | Active-low host read strobe |
| addr | input | 7 | Host register address |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data |
| host_doe | output | 1 | Read data enable for the external bus pad driver |
| evt_sync | input | 1 | One-cycle transfer event for event mode |
| cfg_slv | output | NCH*NREG*16 | Slave values, channel-major, register 0 in the least significant bits |

## Verification
The assertions assume that the host keeps `addr` and `host_din` stable around the rising edge of `wr_n`. They also assume that one write strobe is fully synchronised before the next one, and that the mode and hold bits do not change in the same device cycle as an `evt_sync` pulse. The bench drives every host strobe from the falling clock edge and holds the strobe low for a full clock period. Between any two writes it waits at least one clock. It also waits ten clocks before pulsing `evt_sync`, so every write has been marked pending before the pulse arrives. The soft and hard resets are held low for whole clock cycles, with `wr_n` idle high.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the dual-rank configuration bank.
// Assumes a 16-bit host data bus and a 7-bit host address.
package cfgb_pkg;
    localparam int DW = 16;
    localparam int AW = 7;

    localparam logic [AW-1:0] ADDR_MAIN = 7'h0C;
    localparam logic [AW-1:0] ADDR_DEV  = 7'h78;

    localparam int BIT_IMM   = 15;
    localparam int BIT_HOLD  = 12;
    localparam int BIT_BCAST = 0;

    typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/cfgb_host_rank.sv
`timescale 1ns/1ps
// Module: host-side rank. Holds the master registers of all channels and the
// two control words. It also records which channels the latest write touched.
// Assumes addr and din are stable at the rising edge of wr_n. There is no
// free-running clock in this domain, so the hard reset clears it asynchronously.
module cfgb_host_rank
    import cfgb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NREG = 8
) (
    input  logic                     hard_rst_n,
    input  logic                     wr_n,
    input  logic [AW-1:0]            addr,
    input  word_t                    din,
    output word_t                    ctl_main,
    output word_t                    ctl_dev,
    output logic [NCH*NREG*DW-1:0]   mst,
    output logic                     tag_cfg,
    output logic [NCH-1:0]           tag_chmask
);
    localparam int CHW = $clog2(NCH);
    localparam int RW  = $clog2(NREG);

    logic             is_cfg;
    logic [NCH-1:0]   wr_chmask;

    // Decode whether the address hits a configuration word.
    assign is_cfg = (int'(addr) < NREG);

    // Work out the target channels from the current device control word.
    always_comb begin
        wr_chmask = '0;
        if (ctl_dev[BIT_BCAST]) wr_chmask = '1;
        else                    wr_chmask[ctl_dev[CHW:1]] = 1'b1;
    end

    // Capture the host write into the masters, the control words and the write tag.
    always_ff @(posedge wr_n or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            ctl_main   <= '0;
            ctl_dev    <= '0;
            mst        <= '0;
            tag_cfg    <= 1'b0;
            tag_chmask <= '0;
        end else begin
            tag_cfg    <= is_cfg;
            tag_chmask <= is_cfg ? wr_chmask : '0;
            if (addr == ADDR_MAIN) ctl_main <= din;
            if (addr == ADDR_DEV)  ctl_dev  <= din;
            if (is_cfg) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (wr_chmask[ch])
                        mst[(ch*NREG + int'(addr[RW-1:0]))*DW +: DW] <= din;
                end
            end
        end
    end
endmodule

// File: rtl/cfgb_wr_sync.sv
`timescale 1ns/1ps
// Module: brings the write strobe into the device clock domain. Two flops
// synchronise it, a third finds the rising edge, and a countdown fires the
// immediate-mode transfer SYNC_CYC cycles after that edge.
// Assumes wr_n idles high and that writes are spaced wider than the sync chain.
module cfgb_wr_sync #(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic wr_seen,
    output logic imm_fire
);
    localparam int CW = $clog2(SYNC_CYC + 1);

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Shift the strobe through the synchroniser and edge flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], wr_n};
    end

    assign wr_seen = sync_q[1] & ~sync_q[2];

    // Count down from the detected edge; each new edge restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (wr_seen)        cnt_q <= CW'(SYNC_CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign imm_fire = (cnt_q == CW'(1));
endmodule

// File: rtl/cfgb_slave_rank.sv
`timescale 1ns/1ps
// Module: device-side rank. Each channel keeps a slave set and a pending flag.
// On a transfer, every pending channel copies its whole master set. A write
// marked in the same cycle as a transfer stays pending for the next one.
// Assumes the master values are stable whenever mark or xfer is active.
module cfgb_slave_rank
    import cfgb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*NREG*DW-1:0]  mst,
    input  logic [NCH-1:0]          mark,
    input  logic                    xfer,
    output logic [NCH*NREG*DW-1:0]  cfg_slv
);
    localparam int SW = NREG * DW;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [SW-1:0] slv_q;
        logic          pend_q;

        // Update this channel's slave set and its pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slv_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                if (xfer && pend_q) slv_q <= mst[ch*SW +: SW];
                pend_q <= (pend_q && !xfer) || mark[ch];
            end
        end

        assign cfg_slv[ch*SW +: SW] = slv_q;
    end
endmodule

// File: rtl/cfg_dual_rank_bank.sv
`timescale 1ns/1ps
// Module: top of the dual-rank configuration bank. Wires the host rank, the
// strobe synchroniser and the slave rank together, chooses the transfer
// source, and muxes host reads.
// Assumes the control words are quasi-static around evt_sync pulses.
module cfg_dual_rank_bank
    import cfgb_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int NREG     = 8,
    parameter int SYNC_CYC = 4
) (
    input  logic                    clk,
    input  logic                    hard_rst_n,
    input  logic                    soft_rst_n,
    input  logic                    wr_n,
    input  logic                    rd_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           host_din,
    output logic [DW-1:0]           host_dout,
    output logic                    host_doe,
    input  logic                    evt_sync,
    output logic [NCH*NREG*DW-1:0]  cfg_slv
);
    localparam int CHW = $clog2(NCH);
    localparam int RW  = $clog2(NREG);

    word_t                   ctl_main, ctl_dev;
    logic [NCH*NREG*DW-1:0]  mst;
    logic                    tag_cfg;
    logic [NCH-1:0]          tag_chmask;
    logic                    dev_rst_n;
    logic                    wr_seen, imm_fire;
    logic                    ctl_imm, ctl_hold;
    logic                    xfer;
    logic [NCH-1:0]          mark;

    assign dev_rst_n = hard_rst_n & soft_rst_n;
    assign ctl_imm   = ctl_main[BIT_IMM];
    assign ctl_hold  = ctl_main[BIT_HOLD];

    cfgb_host_rank #(.NCH(NCH), .NREG(NREG)) u_host (
        .hard_rst_n (hard_rst_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .din        (host_din),
        .ctl_main   (ctl_main),
        .ctl_dev    (ctl_dev),
        .mst        (mst),
        .tag_cfg    (tag_cfg),
        .tag_chmask (tag_chmask)
    );

    cfgb_wr_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk      (clk),
        .rst_n    (dev_rst_n),
        .wr_n     (wr_n),
        .wr_seen  (wr_seen),
        .imm_fire (imm_fire)
    );

    // Mark channels pending once the synchronised strobe edge arrives.
    assign mark = (wr_seen && tag_cfg) ? tag_chmask : '0;

    // Pick the transfer trigger that the update mode selects.
    assign xfer = ctl_imm ? imm_fire : (evt_sync && !ctl_hold);

    cfgb_slave_rank #(.NCH(NCH), .NREG(NREG)) u_slave (
        .clk     (clk),
        .rst_n   (dev_rst_n),
        .mst     (mst),
        .mark    (mark),
        .xfer    (xfer),
        .cfg_slv (cfg_slv)
    );

    assign host_doe = ~rd_n;

    // Select the read data from the addressed register.
    always_comb begin
        host_dout = '0;
        if (!rd_n) begin
            if (addr == ADDR_MAIN)      host_dout = ctl_main;
            else if (addr == ADDR_DEV)  host_dout = ctl_dev;
            else if (int'(addr) < NREG)
                host_dout = cfg_slv[(int'(ctl_dev[CHW:1])*NREG + int'(addr[RW-1:0]))*DW +: DW];
        end
    end
endmodule

// File: rtl/cfgb_checker.sv
`timescale 1ns/1ps
// Module: property checker for cfg_dual_rank_bank, attached with bind.
// Assumes the control words do not change in the cycle of an evt_sync pulse.
module cfgb_checker #(
    parameter int NCH  = 4,
    parameter int NREG = 8
) (
    input logic                   clk,
    input logic                   hard_rst_n,
    input logic                   soft_rst_n,
    input logic                   evt_sync,
    input logic                   ctl_imm,
    input logic                   ctl_hold,
    input logic                   xfer,
    input logic [NCH*NREG*16-1:0] cfg_slv
);
    // R1: hard reset leaves the slave rank cleared
    a_r1_hard_clears: assert property (@(posedge clk)
        !hard_rst_n |=> (cfg_slv == '0));

    // R2: soft reset leaves the slave rank cleared
    a_r2_soft_clears: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !soft_rst_n |=> (cfg_slv == '0));

    // R4: slave values change only on the edge after a transfer trigger
    a_r4_change_needs_xfer: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !soft_rst_n)
        ((cfg_slv != $past(cfg_slv)) && $past(hard_rst_n && soft_rst_n)) |-> $past(xfer));

    // R6: in event mode, nothing moves without a sync pulse
    a_r6_event_needs_pulse: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !soft_rst_n)
        (!ctl_imm && !evt_sync) |=> $stable(cfg_slv));

    // R7: hold freezes the slaves in event mode
    a_r7_hold_freezes: assert property (@(posedge clk)
        disable iff (!hard_rst_n || !soft_rst_n)
        (!ctl_imm && ctl_hold) |=> $stable(cfg_slv));
endmodule

bind cfg_dual_rank_bank cfgb_checker #(.NCH(NCH), .NREG(NREG)) u_chk (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .evt_sync   (evt_sync),
    .ctl_imm    (ctl_imm),
    .ctl_hold   (ctl_hold),
    .xfer       (xfer),
    .cfg_slv    (cfg_slv)
);

// File: tb/tb_cfg_dual_rank_bank.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_cfg_dual_rank_bank;
    localparam int NCH  = 4;
    localparam int NREG = 8;

    logic                    clk = 1'b0;
    logic                    hard_rst_n = 1'b0;
    logic                    soft_rst_n = 1'b0;
    logic                    wr_n = 1'b1;
    logic                    rd_n = 1'b1;
    logic [6:0]              addr = '0;
    logic [15:0]             host_din = '0;
    logic [15:0]             host_dout;
    logic                    host_doe;
    logic                    evt_sync = 1'b0;
    logic [NCH*NREG*16-1:0]  cfg_slv;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    cfg_dual_rank_bank #(.NCH(NCH), .NREG(NREG), .SYNC_CYC(4)) dut (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .wr_n(wr_n), .rd_n(rd_n), .addr(addr), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .evt_sync(evt_sync),
        .cfg_slv(cfg_slv)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; host_din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_rd(input logic [6:0] a, output logic [15:0] d, output logic oe);
        addr = a; rd_n = 1'b0;
        #2;
        d = host_dout; oe = host_doe;
        rd_n = 1'b1;
        #1;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic        oe;
        host_rd(a, d, oe);
        chk(tag, d, exp);
    endtask

    task automatic evt_pulse();
        repeat (10) @(negedge clk);
        evt_sync = 1'b1;
        @(negedge clk);
        evt_sync = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        logic        oe;
        repeat (5) @(negedge clk);
        hard_rst_n = 1'b1; soft_rst_n = 1'b1;
        @(negedge clk);
        chk("R3 idle doe", {15'b0, host_doe}, 16'h0000);
        chk("R3 idle dout", host_dout, 16'h0000);
        host_rd(7'h0C, d, oe);
        chk("R3 doe while reading", {15'b0, oe}, 16'h0001);
        chk("R1 main ctl after reset", d, 16'h0000);
        rd_chk("R1 dev ctl after reset", 7'h78, 16'h0000);
        rd_chk("R1 slave after reset", 7'h00, 16'h0000);
        chk("R1 slave port after reset", 16'(cfg_slv != '0), 16'h0000);
        rd_chk("R3 unmapped address", 7'h40, 16'h0000);
    endtask

    task automatic t_r5_immediate();
        host_wr(7'h0C, 16'h9000);
        host_wr(7'h00, 16'h1234);
        rd_chk("R4 slave unchanged after strobe", 7'h00, 16'h0000);
        repeat (5) @(negedge clk);
        rd_chk("R5 not yet after 5 edges", 7'h00, 16'h0000);
        repeat (2) @(negedge clk);
        rd_chk("R5 transferred by 7 edges", 7'h00, 16'h1234);
        chk("R5 slave port ch0 reg0", cfg_slv[15:0], 16'h1234);
        rd_chk("R3 main ctl readback", 7'h0C, 16'h9000);
    endtask

    task automatic t_r6_event();
        host_wr(7'h0C, 16'h0000);
        host_wr(7'h01, 16'hBEEF);
        repeat (10) @(negedge clk);
        rd_chk("R6 no transfer without pulse", 7'h01, 16'h0000);
        evt_pulse();
        rd_chk("R6 transfer on pulse", 7'h01, 16'hBEEF);
        rd_chk("R9 whole set copied", 7'h00, 16'h1234);
    endtask

    task automatic t_r7_hold();
        host_wr(7'h0C, 16'h1000);
        host_wr(7'h02, 16'h0F0F);
        evt_pulse();
        repeat (2) @(negedge clk);
        rd_chk("R7 hold blocks event", 7'h02, 16'h0000);
        host_wr(7'h0C, 16'h0000);
        evt_pulse();
        rd_chk("R7 pending kept through hold", 7'h02, 16'h0F0F);
    endtask

    task automatic t_r8_broadcast();
        host_wr(7'h78, 16'h0001);
        host_wr(7'h03, 16'hA5A5);
        evt_pulse();
        for (int ch = 0; ch < NCH; ch++) begin
            host_wr(7'h78, 16'(ch << 1));
            rd_chk($sformatf("R8 broadcast ch%0d", ch), 7'h03, 16'hA5A5);
            chk($sformatf("R8 broadcast port ch%0d", ch), cfg_slv[(ch*NREG+3)*16 +: 16], 16'hA5A5);
        end
        host_wr(7'h78, 16'h0004);
        host_wr(7'h04, 16'h5A5A);
        evt_pulse();
        rd_chk("R8 single channel write ch2", 7'h04, 16'h5A5A);
        host_wr(7'h78, 16'h0002);
        rd_chk("R9 unwritten ch1 untouched", 7'h04, 16'h0000);
        rd_chk("R3 dev ctl readback", 7'h78, 16'h0002);
        chk("R9 ch3 port untouched", cfg_slv[(3*NREG+4)*16 +: 16], 16'h0000);
    endtask

    task automatic t_r2_soft();
        host_wr(7'h78, 16'h0000);
        host_wr(7'h0C, 16'h9000);
        @(negedge clk);
        soft_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        soft_rst_n = 1'b1;
        @(negedge clk);
        chk("R2 slaves cleared", 16'(cfg_slv != '0), 16'h0000);
        rd_chk("R2 main ctl survives", 7'h0C, 16'h9000);
        host_wr(7'h00, 16'h7777);
        repeat (10) @(negedge clk);
        rd_chk("R2 new write transferred", 7'h00, 16'h7777);
        rd_chk("R2 master survived soft reset", 7'h01, 16'hBEEF);
    endtask

    task automatic t_r1_hard();
        @(negedge clk);
        hard_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        hard_rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 main ctl cleared", 7'h0C, 16'h0000);
        rd_chk("R1 slave cleared", 7'h01, 16'h0000);
        host_wr(7'h00, 16'h4242);
        evt_pulse();
        rd_chk("R1 post-reset write moves", 7'h00, 16'h4242);
        rd_chk("R1 master cleared by hard reset", 7'h01, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_r5_immediate();
        t_r6_event();
        t_r7_hold();
        t_r8_broadcast();
        t_r2_soft();
        t_r1_hard();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule